// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block holds the debug registers next to a processor pipeline. It compares every instruction fetch and every data access against four breakpoint slots. Each slot has an address, an access-type selector, a length selector and two enable bits. When one or more enabled slots match in a cycle, the block latches sticky hit flags in its status register. In the following cycle it raises a debug-exception request, together with a vector that names the slots that hit.

Software reaches the six debug registers through a plain register port: a 3-bit index, a write strobe, write data and a combinational read. The pipeline supplies a resume flag, which suppresses instruction breakpoints for the instruction it accompanies. It also supplies an extensions enable, which gives meaning to the otherwise undefined access-type code. Exception delivery, privilege checks and task switching belong to the surrounding core.

The request logic is a two-state machine. `ST_WATCH` is the quiet state. The transition `HIT_SEEN` moves it to `ST_REPORT` when any slot hits. In `ST_REPORT` the request is high. `HIT_AGAIN` keeps it there while hits continue in consecutive cycles, and `QUIET` returns it to `ST_WATCH` in a cycle with no hit.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: Register index 0 to 3 selects the breakpoint address of slots 0 to 3, which reads back as written. Index 4 selects status and index 5 selects control. Indices 6 and 7 read as zero and ignore writes.
- R2: The control register keeps bits 0 to 9, bit 13 and bits 31:16 as written. Bit 10 reads as 1, and bits 11, 12, 14 and 15 read as 0. Slot n takes its access type from bits 17+4n:16+4n and its length from bits 19+4n:18+4n.
- R3: Slot n is active when bit 2n (local) or bit 2n+1 (global) of control is set. After control is written with zero, no slot hits and no request is raised.
- R4: With access type 00, a slot hits on a valid fetch whose address equals the slot address exactly, whatever its length code. Data accesses never hit such a slot.
- R5: While the resume flag is high, fetch hits are suppressed. Data hits are not affected by the resume flag.
- R6: Access type 01 hits on data writes only, and access type 11 hits on data reads and writes. Neither ever hits on a fetch.
- R7: Access type 10 never hits while the extensions enable is low. While it is high, this code hits on data reads only.
- R8: A data access hits when any byte it touches lies in the slot range. The range starts at the slot address with its low bits cleared for the length: code 00 gives 1 byte, 01 gives 2 bytes (bit 0 cleared), 11 gives 4 bytes (bits 1:0 cleared), and 10 counts as 1 byte. The access size code is 00 for 1 byte, 01 for 2 bytes, and 10 or 11 for 4 bytes.
- R9: Status bits 3:0 are the slot hit flags. They stay set until software writes 0 to them, several can set in one cycle, and a hit in the same cycle as a status write leaves its flag set. Bits 13, 14 and 15 are plain software-writable flags.
- R10: Status bits 31:16 and 11:4 always read as 1, and bit 12 reads as 0.
- R11: A cycle in which any slot hits is followed by exactly one cycle with the request high, with the hitting slots shown on the slot vector. A run of hit cycles gives a request of the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Instruction fetch present this cycle |
| fetch_addr | input | ADDR_W | Fetch address |
| dacc_valid | input | 1 | Data access present this cycle |
| dacc_addr | input | ADDR_W | Lowest byte address of the data access |
| dacc_size | input | 2 | Access size code: 00 = 1 byte, 01 = 2 bytes, 1x = 4 bytes |
| dacc_write | input | 1 | 1 = write, 0 = read |
| resume_flag | input | 1 | Suppresses fetch breakpoints for this instruction |
| ext_en | input | 1 | Debug extensions enable |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_idx) |
| dbg_req | output | 1 | Debug-exception request |
| req_slots | output | 4 | Slots that caused the current request |

## Verification
A corrupted slot configuration or a bad comparator shows up at the very next edge. It appears as a missing or extra request and a wrong bit in the slot vector, and it is visible in the status readback in the same cycle. A hit flag that clears by itself or fails to set is caught by the next status read: the bench reads status right after each access and again after idle cycles. A request state that sticks high shows up one cycle after the last hit, where the bench expects the request to drop.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_SLOTS = 4;
    localparam int IDX_W     = 3;

    localparam logic [IDX_W-1:0] IDX_STS  = 3'd4;
    localparam logic [IDX_W-1:0] IDX_CTRL = 3'd5;

    // access type selector per slot
    typedef enum logic [1:0] {
        RW_FETCH = 2'b00,
        RW_WRITE = 2'b01,
        RW_EXT   = 2'b10,
        RW_DATA  = 2'b11
    } rw_sel_e;

    typedef struct packed {
        logic       l_en;
        logic       g_en;
        rw_sel_e    rw;
        logic [1:0] len;
    } slot_cfg_t;

    typedef enum logic {
        ST_WATCH  = 1'b0,
        ST_REPORT = 1'b1
    } req_state_e;

    // low address bits ignored for a given length code
    function automatic logic [1:0] len_mask(input logic [1:0] len);
        logic [1:0] m;
        unique case (len)
            2'b01:   m = 2'b01;
            2'b11:   m = 2'b11;
            default: m = 2'b00;
        endcase
        return m;
    endfunction

    // offset of the last byte touched by an access of the given size code
    function automatic logic [1:0] size_last(input logic [1:0] sz);
        logic [1:0] l;
        unique case (sz)
            2'b00:   l = 2'd0;
            2'b01:   l = 2'd1;
            default: l = 2'd3;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/dbg_slot_match.sv
module dbg_slot_match
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  slot_cfg_t          cfg,
    input  logic [ADDR_W-1:0]  bp_addr,
    input  logic               fetch_valid,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic               dacc_valid,
    input  logic [ADDR_W-1:0]  dacc_addr,
    input  logic [1:0]         dacc_size,
    input  logic               dacc_write,
    input  logic               resume_flag,
    input  logic               ext_en,
    output logic               hit
);

    localparam int EXT_W = ADDR_W + 1;

    logic [1:0]       mask;
    logic [EXT_W-1:0] rng_lo;
    logic [EXT_W-1:0] rng_hi;
    logic [EXT_W-1:0] acc_lo;
    logic [EXT_W-1:0] acc_hi;
    logic             overlap;
    logic             kind_ok;
    logic             fetch_hit;
    logic             data_hit;
    logic             active;

    assign mask   = len_mask(cfg.len);
    assign rng_lo = {1'b0, bp_addr & ~ADDR_W'(mask)};
    assign rng_hi = rng_lo | EXT_W'(mask);
    assign acc_lo = {1'b0, dacc_addr};
    assign acc_hi = acc_lo + EXT_W'(size_last(dacc_size));

    // byte ranges intersect; widened so a top-of-space access cannot wrap
    assign overlap = (acc_lo <= rng_hi) && (acc_hi >= rng_lo);

    always_comb begin
        unique case (cfg.rw)
            RW_FETCH: kind_ok = 1'b0;
            RW_WRITE: kind_ok = dacc_write;
            RW_EXT:   kind_ok = ext_en && !dacc_write;
            RW_DATA:  kind_ok = 1'b1;
            default:  kind_ok = 1'b0;
        endcase
    end

    assign active    = cfg.l_en | cfg.g_en;
    assign fetch_hit = (cfg.rw == RW_FETCH) && fetch_valid && !resume_flag
                       && (fetch_addr == bp_addr);
    assign data_hit  = dacc_valid && kind_ok && overlap;
    assign hit       = active && (fetch_hit || data_hit);

endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_we,
    input  logic [IDX_W-1:0]                  reg_idx,
    input  logic [REG_W-1:0]                  reg_wdata,
    output logic [REG_W-1:0]                  reg_rdata,
    input  logic [NUM_SLOTS-1:0]              slot_hits,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  bp_addr,
    output slot_cfg_t [NUM_SLOTS-1:0]         slot_cfg,
    output logic [NUM_SLOTS-1:0]              sts_hits,
    output logic [2*NUM_SLOTS-1:0]            ctrl_en
);

    localparam int EN_W  = 2 * NUM_SLOTS;
    localparam int FLD_W = 4 * NUM_SLOTS;

    logic [NUM_SLOTS-1:0][ADDR_W-1:0] bp_q;
    logic [EN_W-1:0]                  en_q;
    logic                             le_q;
    logic                             ge_q;
    logic                             gd_q;
    logic [FLD_W-1:0]                 fld_q;
    logic [NUM_SLOTS-1:0]             flag_q;
    logic [NUM_SLOTS-1:0]             flag_d;
    logic                             bd_q;
    logic                             bs_q;
    logic                             bt_q;

    logic                             wr_sts;
    logic                             wr_ctrl;
    logic [REG_W-1:0]                 ctrl_img;
    logic [REG_W-1:0]                 sts_img;
    logic                             unused_wbits;

    assign wr_sts  = reg_we && (reg_idx == IDX_STS);
    assign wr_ctrl = reg_we && (reg_idx == IDX_CTRL);

    // address registers, one per slot
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_addr
        logic wr_this;
        assign wr_this = reg_we && (reg_idx == IDX_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bp_q[s] <= '0;
            end else if (wr_this) begin
                bp_q[s] <= reg_wdata[ADDR_W-1:0];
            end
        end

        assign slot_cfg[s] = '{
            l_en: en_q[2*s],
            g_en: en_q[2*s+1],
            rw:   rw_sel_e'(fld_q[4*s +: 2]),
            len:  fld_q[4*s+2 +: 2]
        };
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            le_q  <= 1'b0;
            ge_q  <= 1'b0;
            gd_q  <= 1'b0;
            fld_q <= '0;
        end else if (wr_ctrl) begin
            en_q  <= reg_wdata[EN_W-1:0];
            le_q  <= reg_wdata[8];
            ge_q  <= reg_wdata[9];
            gd_q  <= reg_wdata[13];
            fld_q <= reg_wdata[16 +: FLD_W];
        end
    end

    // sticky hit flags: software write first, then hits are merged on top
    always_comb begin
        flag_d = flag_q;
        if (wr_sts) begin
            flag_d = reg_wdata[NUM_SLOTS-1:0];
        end
        flag_d = flag_d | slot_hits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            bd_q   <= 1'b0;
            bs_q   <= 1'b0;
            bt_q   <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (wr_sts) begin
                bd_q <= reg_wdata[13];
                bs_q <= reg_wdata[14];
                bt_q <= reg_wdata[15];
            end
        end
    end

    assign ctrl_img = {fld_q, 2'b00, gd_q, 2'b00, 1'b1, ge_q, le_q, en_q};
    assign sts_img  = {16'hFFFF, bt_q, bs_q, bd_q, 1'b0, 8'hFF, flag_q};

    always_comb begin
        reg_rdata = '0;
        if (!reg_idx[2]) begin
            reg_rdata = REG_W'(bp_q[reg_idx[1:0]]);
        end else begin
            unique case (reg_idx)
                IDX_STS:  reg_rdata = sts_img;
                IDX_CTRL: reg_rdata = ctrl_img;
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign unused_wbits = ^{reg_wdata[12:10], reg_wdata[7:4]};

    assign bp_addr  = bp_q;
    assign sts_hits = flag_q;
    assign ctrl_en  = en_q;

endmodule

// File: rtl/dbg_req_fsm.sv
module dbg_req_fsm
    import dbg_bkpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] slot_hits,
    output logic                 dbg_req,
    output logic [NUM_SLOTS-1:0] req_slots
);

    req_state_e           state_q;
    req_state_e           state_d;
    logic [NUM_SLOTS-1:0] slots_q;
    logic                 any_hit;

    assign any_hit = |slot_hits;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WATCH;
            slots_q <= '0;
        end else begin
            state_q <= state_d;
            slots_q <= slot_hits;
        end
    end

    // transitions: HIT_SEEN, HIT_AGAIN, QUIET
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH:  state_d = any_hit ? ST_REPORT : ST_WATCH;
            ST_REPORT: state_d = any_hit ? ST_REPORT : ST_WATCH;
            default:   state_d = ST_WATCH;
        endcase
    end

    // outputs
    always_comb begin
        dbg_req   = 1'b0;
        req_slots = '0;
        unique case (state_q)
            ST_WATCH:  ;
            ST_REPORT: begin
                dbg_req   = 1'b1;
                req_slots = slots_q;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fetch_valid,
    input  logic [ADDR_W-1:0]     fetch_addr,
    input  logic                  dacc_valid,
    input  logic [ADDR_W-1:0]     dacc_addr,
    input  logic [1:0]            dacc_size,
    input  logic                  dacc_write,
    input  logic                  resume_flag,
    input  logic                  ext_en,
    input  logic                  reg_we,
    input  logic [IDX_W-1:0]      reg_idx,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  dbg_req,
    output logic [NUM_SLOTS-1:0]  req_slots
);

    logic [NUM_SLOTS-1:0][ADDR_W-1:0] bp_addr;
    slot_cfg_t [NUM_SLOTS-1:0]        slot_cfg;
    logic [NUM_SLOTS-1:0]             slot_hits;
    logic [NUM_SLOTS-1:0]             sts_hits;
    logic [2*NUM_SLOTS-1:0]           ctrl_en;

    dbg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .slot_hits (slot_hits),
        .bp_addr   (bp_addr),
        .slot_cfg  (slot_cfg),
        .sts_hits  (sts_hits),
        .ctrl_en   (ctrl_en)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        dbg_slot_match #(.ADDR_W(ADDR_W)) u_match (
            .cfg         (slot_cfg[s]),
            .bp_addr     (bp_addr[s]),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .dacc_valid  (dacc_valid),
            .dacc_addr   (dacc_addr),
            .dacc_size   (dacc_size),
            .dacc_write  (dacc_write),
            .resume_flag (resume_flag),
            .ext_en      (ext_en),
            .hit         (slot_hits[s])
        );
    end

    dbg_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_hits (slot_hits),
        .dbg_req   (dbg_req),
        .req_slots (req_slots)
    );

endmodule

// File: rtl/dbg_bkpt_chk.sv
module dbg_bkpt_chk
    import dbg_bkpt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dacc_valid,
    input  logic                  resume_flag,
    input  logic                  reg_we,
    input  logic [IDX_W-1:0]      reg_idx,
    input  logic [REG_W-1:0]      reg_rdata,
    input  logic                  dbg_req,
    input  logic [NUM_SLOTS-1:0]  req_slots,
    input  logic [NUM_SLOTS-1:0]  sts_b,
    input  logic [2*NUM_SLOTS-1:0] en_bits
);

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> (req_slots != '0)); // R11

    AST_NO_CAUSE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_req |-> (req_slots == '0)); // R11

    AST_REQ_FLAGS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> ((req_slots & ~sts_b) == '0)); // R9

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sts_b) & ~sts_b) != '0) |-> $past(reg_we && (reg_idx == IDX_STS))); // R9

    AST_RESUME_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_flag && !dacc_valid) |=> !dbg_req); // R5

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_bits == '0) |=> !dbg_req); // R3

    AST_STS_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_STS) |-> (reg_rdata[31:16] == 16'hFFFF && reg_rdata[11:4] == 8'hFF
                                  && !reg_rdata[12])); // R10

    AST_CTRL_BIT10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_CTRL) |-> reg_rdata[10]); // R2

endmodule

bind dbg_bkpt_unit dbg_bkpt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dacc_valid  (dacc_valid),
    .resume_flag (resume_flag),
    .reg_we      (reg_we),
    .reg_idx     (reg_idx),
    .reg_rdata   (reg_rdata),
    .dbg_req     (dbg_req),
    .req_slots   (req_slots),
    .sts_b       (sts_hits),
    .en_bits     (ctrl_en)
);

// File: tb/tb_dbg_bkpt_unit.sv
module tb_dbg_bkpt_unit;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          dacc_valid = 1'b0;
    logic [AW-1:0] dacc_addr = '0;
    logic [1:0]    dacc_size = '0;
    logic          dacc_write = 1'b0;
    logic          resume_flag = 1'b0;
    logic          ext_en = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_idx = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          dbg_req;
    logic [3:0]    req_slots;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    dbg_bkpt_unit #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .dacc_valid(dacc_valid), .dacc_addr(dacc_addr), .dacc_size(dacc_size),
        .dacc_write(dacc_write), .resume_flag(resume_flag), .ext_en(ext_en),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dbg_req(dbg_req), .req_slots(req_slots)
    );

    // kind: 0 fetch, 1 read, 2 write
    typedef struct packed {
        logic [1:0]  rw;
        logic [1:0]  len;
        logic [1:0]  kind;
        logic [1:0]  size;
        logic        res;
        logic        de;
        logic        exp;
        logic [31:0] bp;
        logic [31:0] acc;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h1000, 32'h1000}, // R4 exact fetch
        '{2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h1001}, // R4 miss
        '{2'd0, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h1001}, // R4 LEN ignored
        '{2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 32'h1000, 32'h1000}, // R5 resume
        '{2'd0, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h1000}, // R4 data on fetch slot
        '{2'd1, 2'd0, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 32'h2000, 32'h2000}, // R6 write
        '{2'd1, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h2000, 32'h2000}, // R6 read on write slot
        '{2'd3, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 32'h2000, 32'h2000}, // R6 read
        '{2'd3, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h2000, 32'h2000}, // R6 fetch never
        '{2'd3, 2'd3, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 32'h3002, 32'h3003}, // R8 4-byte range
        '{2'd3, 2'd3, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h3000, 32'h3004}, // R8 past range
        '{2'd3, 2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h3005, 32'h3004}, // R8 2-byte access
        '{2'd3, 2'd1, 2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 32'h3007, 32'h3004}, // R8 4-byte access
        '{2'd3, 2'd1, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 32'h3006, 32'h3008}, // R8 miss
        '{2'd2, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h4000, 32'h4000}, // R7 ext off
        '{2'd2, 2'd0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 32'h4000, 32'h4000}, // R7 ext on read
        '{2'd2, 2'd0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 32'h4000, 32'h4000}, // R7 ext on write
        '{2'd3, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 32'h2000, 32'h2000}, // R5 data unaffected
        '{2'd1, 2'd3, 2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 32'h5000, 32'h4FFE}, // R8 straddle
        '{2'd3, 2'd2, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h6001, 32'h6000}, // R8 LEN 10 is 1 byte
        '{2'd3, 2'd2, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 32'h6001, 32'h6001}  // R8 LEN 10 hit
    };

    function automatic string vtag(input vec_t v);
        if (v.rw == 2'd0) return v.res ? "R5" : "R4";
        if (v.rw == 2'd2) return "R7";
        if (v.res) return "R5";
        if (v.len != 2'd0 || v.size != 2'd0) return "R8";
        return "R6";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] idx, output logic [31:0] d);
        reg_idx = idx;
        #1;
        d = reg_rdata;
    endtask

    task automatic drive_acc(input logic [1:0] kind, input logic [31:0] a, input logic [1:0] sz,
                             input logic res, input logic de);
        fetch_valid = (kind == 2'd0);
        fetch_addr  = a;
        dacc_valid  = (kind != 2'd0);
        dacc_addr   = a;
        dacc_size   = sz;
        dacc_write  = (kind == 2'd2);
        resume_flag = res;
        ext_en      = de;
    endtask

    task automatic idle_acc();
        fetch_valid = 1'b0; dacc_valid = 1'b0; dacc_write = 1'b0;
        resume_flag = 1'b0; ext_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        reg_rd(3'd4, rd); chk("R10 reset status", rd, 32'hFFFF0FF0);
        reg_rd(3'd5, rd); chk("R2 reset control", rd, 32'h00000400);
        reg_rd(3'd2, rd); chk("R1 reset address", rd, 32'h0);
        chk("R11 reset request", {31'd0, dbg_req}, 32'd0);

        // R1: address registers and unused indices
        for (int i = 0; i < 4; i++) reg_wr(3'(i), 32'hA5A50000 + 32'(i * 17));
        for (int i = 0; i < 4; i++) begin
            reg_rd(3'(i), rd); chk("R1 address readback", rd, 32'hA5A50000 + 32'(i * 17));
        end
        reg_wr(3'd6, 32'hFFFFFFFF);
        reg_rd(3'd6, rd); chk("R1 index 6 reads zero", rd, 32'h0);
        reg_rd(3'd0, rd); chk("R1 index 6 write ignored", rd, 32'hA5A50000);

        // vector table, slot 0, alternating local / global enable (R3)
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] ctrl;
            v = VEC[i];
            ctrl = ((i % 2) != 0 ? 32'h2 : 32'h1) | (32'(v.rw) << 16) | (32'(v.len) << 18);
            reg_wr(3'd0, v.bp);
            reg_wr(3'd5, ctrl);
            reg_wr(3'd4, 32'h0);
            drive_acc(v.kind, v.acc, v.size, v.res, v.de);
            @(negedge clk);
            idle_acc();
            chk(vtag(v), {31'd0, dbg_req}, {31'd0, v.exp});
            chk("R11 slot vector", {28'd0, req_slots}, {28'd0, 3'd0, v.exp});
            reg_rd(3'd4, rd); chk("R9 flag after access", {31'd0, rd[0]}, {31'd0, v.exp});
            @(negedge clk);
            chk("R11 one-cycle request", {31'd0, dbg_req}, 32'd0);
        end

        // several slots at once; slot 3 disabled
        reg_wr(3'd0, 32'h7000); reg_wr(3'd1, 32'h7001);
        reg_wr(3'd2, 32'h7000); reg_wr(3'd3, 32'h7000);
        reg_wr(3'd5, 32'h33330025);
        reg_wr(3'd4, 32'h0);
        drive_acc(2'd1, 32'h7000, 2'd1, 1'b0, 1'b0);
        @(negedge clk);
        idle_acc();
        chk("R11 multi-slot vector", {28'd0, req_slots}, 32'h7);
        reg_rd(3'd4, rd); chk("R9 multi-slot flags", rd, 32'hFFFF0FF7);
        @(negedge clk);
        reg_rd(3'd4, rd); chk("R9 flags sticky when idle", rd, 32'hFFFF0FF7);
        reg_wr(3'd4, 32'h5);
        reg_rd(3'd4, rd); chk("R9 partial clear", rd, 32'hFFFF0FF5);

        // hit in the same cycle as a clearing write
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 3'd4; reg_wdata = 32'h0;
        drive_acc(2'd1, 32'h7001, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        reg_we = 1'b0;
        idle_acc();
        reg_rd(3'd4, rd); chk("R9 hit wins over clear", rd, 32'hFFFF0FF2);

        // run of hits gives a request of equal length
        reg_wr(3'd4, 32'h0);
        drive_acc(2'd1, 32'h7000, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R11 run first", {31'd0, dbg_req}, 32'd1);
        @(negedge clk);
        idle_acc();
        chk("R11 run second", {31'd0, dbg_req}, 32'd1);
        @(negedge clk);
        chk("R11 run ends", {31'd0, dbg_req}, 32'd0);

        // writing zero to control disables everything
        reg_wr(3'd5, 32'h0);
        reg_wr(3'd4, 32'h0);
        drive_acc(2'd1, 32'h7000, 2'd1, 1'b0, 1'b0);
        @(negedge clk);
        idle_acc();
        chk("R3 disabled request", {31'd0, dbg_req}, 32'd0);
        reg_rd(3'd4, rd); chk("R3 disabled flags", rd, 32'hFFFF0FF0);

        // status fixed and software bits
        reg_wr(3'd4, 32'hFFFFFFFF);
        reg_rd(3'd4, rd); chk("R10 status all-ones write", rd, 32'hFFFFEFFF);
        reg_wr(3'd4, 32'h0);
        reg_rd(3'd4, rd); chk("R9 status cleared", rd, 32'hFFFF0FF0);

        // control readback
        reg_wr(3'd5, 32'hFFFFFFFF);
        reg_rd(3'd5, rd); chk("R2 control all-ones", rd, 32'hFFFF27FF);
        reg_wr(3'd5, 32'h0);
        reg_rd(3'd5, rd); chk("R2 control zero", rd, 32'h00000400);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule